// File: doc/BRIEF.md
# Banked GPIO Controller with Line Interrupts

This block is a memory-mapped general-purpose I/O controller for a parameterised number of 32-line banks (three by default, 96 lines). Software configures each line through a word-wide register bus. A line can be an input or an output. Output values can be written whole, or changed bit by bit through set and clear ports that touch only the bits written as one. Input pins pass through a two-flop synchronizer before anything looks at them.

Each line has four independent interrupt-type enables: rising edge, falling edge, high level and low level. Any mix is allowed. Rising plus falling gives an interrupt on either edge, and all four clear masks the line. Each line also has a polarity bit that inverts the synchronized input before detection. Detected conditions latch into a per-line pending word that software clears by writing ones. A second read-only word shows which pending bits came from an edge. One interrupt output combines the pending bits of every bank.

Registers form groups of one word per bank. The group is selected by address bits [7:4] and the bank by bits [3:2]. Reads return data in the same cycle as the address. A write takes effect at the clock edge where the write strobe is high.

Top module: `banked_gpio`

## Requirements
- R1: After reset every configuration word, output word and pending word is zero, so pin_oe, pin_out and irq are all zero.
- R2: The group is bus_addr[7:4] and the bank is bus_addr[3:2]: 0 direction, 1 polarity, 2 data, 3 set, 4 clear, 5 rising enable, 6 falling enable, 7 high enable, 8 low enable, 9 pending, 10 edge-pending. A bank number at or above the bank count, or a group above 10, reads as zero and ignores writes.
- R3: Writing to the set group makes each output bit written as one go high in the next cycle and leaves the bits written as zero unchanged.
- R4: Writing to the clear group makes each output bit written as one go low and leaves the bits written as zero unchanged. Writing to the data group loads the output word whole.
- R5: A one in the direction word drives pin_oe for that line. Bank b's direction bit i maps to pin_oe[32*b+i], and the same mapping applies to pin_out and pin_in. A data read returns the driven value for output lines and the synchronized pin for input lines.
- R6: With the rising enable set, a 0-to-1 change of the polarity-adjusted input sets the pending bit exactly once. The bit is readable after the third rising clock edge following the pin change and is not yet set after the second.
- R7: With the falling enable set, a 1-to-0 change sets the pending bit. With both edge enables set, either change sets it.
- R8: With the high or low level enable set, the pending bit is set on every cycle the matching level is present. It stays set even in the cycle it is written to clear.
- R9: Writing ones to the pending group clears those bits. Bits written as zero keep their value.
- R10: irq is high exactly when some pending bit is set in any bank.
- R11: A polarity bit of one inverts the synchronized input before edge and level detection. A polarity bit of zero means no inversion.
- R12: The edge-pending group reads ones only for pending bits set by an edge event, and it is cleared by the same write-one to the pending group.
- R13: A line whose four enables are all zero never sets its pending bit, whatever its pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address: group in [7:4], bank in [3:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| pin_in | input | 96 | Pin input levels, line n in bit n |
| pin_out | output | 96 | Driven output values |
| pin_oe | output | 96 | Output enables (one = drive) |
| irq | output | 1 | Combined interrupt, high while any line is pending |

## Verification
A wrong output-latch update shows on pin_out in the cycle after the write. A wrong direction word shows on pin_oe at the same point. A fault in the synchronizer or the edge memory changes the cycle where a pending bit first reads as one: it moves that cycle away from the third edge after the pin change, or makes a single edge set the bit twice. A wrong pending word shows on irq at once and on the pending read of its bank. A corrupted enable shows only when its line toggles, so every enable type is driven with a pin change while a neighbouring masked line toggles too.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BANK_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int NWGRP   = 10;

  typedef enum logic [3:0] {
    G_DIR  = 4'd0,
    G_POL  = 4'd1,
    G_DATA = 4'd2,
    G_SET  = 4'd3,
    G_CLR  = 4'd4,
    G_RISE = 4'd5,
    G_FALL = 4'd6,
    G_HIGH = 4'd7,
    G_LOW  = 4'd8,
    G_STAT = 4'd9,
    G_EDGE = 4'd10
  } grp_e;

  function automatic logic [3:0] addr_group(input logic [ADDR_W-1:0] a);
    return a[7:4];
  endfunction

  function automatic logic [1:0] addr_bank(input logic [ADDR_W-1:0] a);
    return a[3:2];
  endfunction

  // pending update: write-one clear first, new events win
  function automatic logic [BANK_W-1:0] w1c_next(input logic [BANK_W-1:0] old,
                                                 input logic [BANK_W-1:0] clr,
                                                 input logic [BANK_W-1:0] ev);
    return (old & ~clr) | ev;
  endfunction

  function automatic logic [BANK_W-1:0] data_view(input logic [BANK_W-1:0] dir,
                                                  input logic [BANK_W-1:0] drv,
                                                  input logic [BANK_W-1:0] pin);
    return (dir & drv) | (~dir & pin);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NWGRP-1:0]  wr_hit,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] sync_in,
  output logic [BANK_W-1:0] dir_o,
  output logic [BANK_W-1:0] out_o,
  output logic [BANK_W-1:0] pol_o,
  output logic [BANK_W-1:0] rise_o,
  output logic [BANK_W-1:0] fall_o,
  output logic [BANK_W-1:0] high_o,
  output logic [BANK_W-1:0] low_o,
  output logic [BANK_W-1:0] stat_o,
  output logic [BANK_W-1:0] edge_o,
  output logic              ev_o
);
  logic [BANK_W-1:0] prev_q;
  logic [BANK_W-1:0] eff_in, rise_ev, fall_ev, lvl_ev, edge_ev, clr_mask;

  assign eff_in   = sync_in ^ pol_o;
  assign rise_ev  = rise_o & eff_in & ~prev_q;
  assign fall_ev  = fall_o & ~eff_in & prev_q;
  assign lvl_ev   = (high_o & eff_in) | (low_o & ~eff_in);
  assign edge_ev  = rise_ev | fall_ev;
  assign clr_mask = wr_hit[G_STAT] ? wdata : '0;
  assign ev_o     = |(edge_ev | lvl_ev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_o  <= '0;
      out_o  <= '0;
      pol_o  <= '0;
      rise_o <= '0;
      fall_o <= '0;
      high_o <= '0;
      low_o  <= '0;
      stat_o <= '0;
      edge_o <= '0;
      prev_q <= '0;
    end else begin
      if (wr_hit[G_DIR])  dir_o  <= wdata;
      if (wr_hit[G_POL])  pol_o  <= wdata;
      if (wr_hit[G_RISE]) rise_o <= wdata;
      if (wr_hit[G_FALL]) fall_o <= wdata;
      if (wr_hit[G_HIGH]) high_o <= wdata;
      if (wr_hit[G_LOW])  low_o  <= wdata;
      if (wr_hit[G_DATA])      out_o <= wdata;
      else if (wr_hit[G_SET])  out_o <= out_o | wdata;
      else if (wr_hit[G_CLR])  out_o <= out_o & ~wdata;
      prev_q <= eff_in;
      stat_o <= w1c_next(stat_o, clr_mask, edge_ev | lvl_ev);
      edge_o <= w1c_next(edge_o, clr_mask, edge_ev);
    end
  end
endmodule

// File: rtl/banked_gpio.sv
module banked_gpio
  import gpio_pkg::*;
#(
  parameter int NBANKS = 3,
  localparam int NL    = NBANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BANK_W-1:0] bus_wdata,
  output logic [BANK_W-1:0] bus_rdata,
  input  logic [NL-1:0]     pin_in,
  output logic [NL-1:0]     pin_out,
  output logic [NL-1:0]     pin_oe,
  output logic              irq
);
  logic [3:0] grp;
  logic [1:0] bnk;
  logic       unused_addr;

  assign grp         = addr_group(bus_addr);
  assign bnk         = addr_bank(bus_addr);
  assign unused_addr = ^bus_addr[1:0];

  logic [NBANKS-1:0][BANK_W-1:0] dir_a, out_a, pol_a, rise_a, fall_a;
  logic [NBANKS-1:0][BANK_W-1:0] high_a, low_a, stat_a, edge_a, sync_a;
  logic [NBANKS-1:0]             ev_a;

  // flattened views for the checker
  logic [NL-1:0] stat_flat, en_flat;
  logic          ev_any;

  genvar b;
  generate
    for (b = 0; b < NBANKS; b++) begin : g_bank
      logic [NWGRP-1:0] hit;
      for (genvar g = 0; g < NWGRP; g++) begin : g_hit
        assign hit[g] = bus_wr && (bnk == 2'(b)) && (grp == 4'(g));
      end

      gpio_sync #(.W(BANK_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in[b*BANK_W +: BANK_W]),
        .q     (sync_a[b])
      );

      gpio_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (hit),
        .wdata   (bus_wdata),
        .sync_in (sync_a[b]),
        .dir_o   (dir_a[b]),
        .out_o   (out_a[b]),
        .pol_o   (pol_a[b]),
        .rise_o  (rise_a[b]),
        .fall_o  (fall_a[b]),
        .high_o  (high_a[b]),
        .low_o   (low_a[b]),
        .stat_o  (stat_a[b]),
        .edge_o  (edge_a[b]),
        .ev_o    (ev_a[b])
      );

      assign pin_out[b*BANK_W +: BANK_W]   = out_a[b];
      assign pin_oe[b*BANK_W +: BANK_W]    = dir_a[b];
      assign stat_flat[b*BANK_W +: BANK_W] = stat_a[b];
      assign en_flat[b*BANK_W +: BANK_W]   = rise_a[b] | fall_a[b] | high_a[b] | low_a[b];
    end
  endgenerate

  assign ev_any = |ev_a;
  assign irq    = |stat_flat;

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NBANKS; i++) begin
      if (bnk == 2'(i)) begin
        case (grp)
          G_DIR:   bus_rdata = dir_a[i];
          G_POL:   bus_rdata = pol_a[i];
          G_DATA:  bus_rdata = data_view(dir_a[i], out_a[i], sync_a[i]);
          G_RISE:  bus_rdata = rise_a[i];
          G_FALL:  bus_rdata = fall_a[i];
          G_HIGH:  bus_rdata = high_a[i];
          G_LOW:   bus_rdata = low_a[i];
          G_STAT:  bus_rdata = stat_a[i];
          G_EDGE:  bus_rdata = edge_a[i];
          default: bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_checker.sv
module gpio_checker #(
  parameter int NBANKS = 3,
  parameter int BW     = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [7:0]       bus_addr,
  input logic [BW-1:0]    bus_wdata,
  input logic [NBANKS*BW-1:0] pin_out,
  input logic [NBANKS*BW-1:0] pin_oe,
  input logic             irq,
  input logic [NBANKS*BW-1:0] stat_flat,
  input logic [NBANKS*BW-1:0] en_flat,
  input logic             ev_any
);
  function automatic logic [BW-1:0] word_of(input logic [NBANKS*BW-1:0] v,
                                            input logic [1:0] b);
    return v[int'(b)*BW +: BW];
  endfunction

  logic bank_ok;
  assign bank_ok = ({30'd0, bus_addr[3:2]} < 32'(NBANKS));

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bank_ok && bus_addr[7:4] == 4'd3) |=>
      (((word_of(pin_out, $past(bus_addr[3:2])) & $past(bus_wdata)) == $past(bus_wdata)) &&
       ((word_of(pin_out, $past(bus_addr[3:2])) & ~$past(bus_wdata)) ==
        (word_of($past(pin_out), $past(bus_addr[3:2])) & ~$past(bus_wdata)))));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bank_ok && bus_addr[7:4] == 4'd4) |=>
      (((word_of(pin_out, $past(bus_addr[3:2])) & $past(bus_wdata)) == '0) &&
       ((word_of(pin_out, $past(bus_addr[3:2])) & ~$past(bus_wdata)) ==
        (word_of($past(pin_out), $past(bus_addr[3:2])) & ~$past(bus_wdata)))));

  p_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bank_ok && bus_addr[7:4] == 4'd0) |=>
      (word_of(pin_oe, $past(bus_addr[3:2])) == $past(bus_wdata)));

  p_masked_r13: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_flat & ~$past(stat_flat) & ~$past(en_flat)) == '0));

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_any));
endmodule

bind banked_gpio gpio_checker #(.NBANKS(NBANKS), .BW(gpio_pkg::BANK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .stat_flat (stat_flat),
  .en_flat   (en_flat),
  .ev_any    (ev_any)
);

// File: tb/banked_gpio_test.sv
module banked_gpio_test;
  localparam int NB = 3;
  localparam int W  = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic [W-1:0]    bus_wdata = '0;
  logic [W-1:0]    bus_rdata;
  logic [NB*W-1:0] pin_in = '0;
  logic [NB*W-1:0] pin_out, pin_oe;
  logic            irq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  banked_gpio #(.NBANKS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] ad(input int g, input int b);
    return 8'(g * 16 + b * 4);
  endfunction

  function automatic logic [W-1:0] bank_of(input logic [NB*W-1:0] v, input int b);
    return v[b*W +: W];
  endfunction

  // per-bit restatement of the data-read rule
  function automatic logic [W-1:0] exp_read(input logic [W-1:0] dir,
                                            input logic [W-1:0] drv,
                                            input logic [W-1:0] pin);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = dir[i] ? drv[i] : pin[i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pins(input logic [NB*W-1:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_all();
    for (int b = 0; b < NB; b++) wr(ad(9, b), '1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r;
    logic [W-1:0] model [NB];
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 pin_oe", W'(|pin_oe), '0);
    chk("R1 pin_out", W'(|pin_out), '0);
    chk("R1 irq", W'(irq), '0);
    for (int b = 0; b < NB; b++) begin
      rd(ad(9, b), r); chk("R1 pending", r, '0);
    end

    // R2 out-of-range bank and group
    wr(8'h2C, 32'hFFFF_FFFF);
    chk("R2 bank3 write ignored", W'(|pin_out), '0);
    rd(8'h2C, r); chk("R2 bank3 reads zero", r, '0);
    wr(8'hB0, 32'h1234_5678);
    rd(8'hB0, r); chk("R2 group11 reads zero", r, '0);

    // R5 direction, data write and data read view
    wr(ad(0, 1), 32'hFFFF_0000);
    chk("R5 pin_oe bank1", bank_of(pin_oe, 1), 32'hFFFF_0000);
    wr(ad(2, 1), 32'h1234_5678);
    chk("R4 data load", bank_of(pin_out, 1), 32'h1234_5678);
    pin_in[63:32] = 32'hAAAA_5555;
    repeat (3) @(negedge clk);
    rd(ad(2, 1), r);
    chk("R5 data read", r, exp_read(32'hFFFF_0000, 32'h1234_5678, 32'hAAAA_5555));

    // R3 / R4 random set, clear and load against a bench model
    for (int b = 0; b < NB; b++) model[b] = bank_of(pin_out, b);
    for (int k = 0; k < 40; k++) begin
      int b  = int'($urandom % NB);
      int op = int'($urandom % 3);
      logic [W-1:0] v = $urandom;
      case (op)
        0: begin wr(ad(3, b), v); model[b] = model[b] | v;  end
        1: begin wr(ad(4, b), v); model[b] = model[b] & ~v; end
        default: begin wr(ad(2, b), v); model[b] = v; end
      endcase
      chk(op == 0 ? "R3 set" : "R4 clear/load", bank_of(pin_out, b), model[b]);
    end

    // R13 masked lines never pend
    set_pins('0);
    clear_all();
    for (int k = 0; k < 6; k++) set_pins({$urandom, $urandom, $urandom});
    for (int b = 0; b < NB; b++) begin
      rd(ad(9, b), r); chk("R13 masked pending", r, '0);
    end
    chk("R13 masked irq", W'(irq), '0);
    set_pins('0);
    clear_all();

    // R6 rising edge, with latency, once per edge
    wr(ad(5, 2), 32'h0000_0020);
    @(negedge clk); pin_in[69] = 1'b1; pin_in[70] = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_addr = ad(9, 2); #1 chk("R6 not before third edge", bus_rdata, '0);
    @(negedge clk);
    #1 chk("R6 pending at third edge", bus_rdata, 32'h0000_0020);
    chk("R10 irq follows pending", W'(irq), 32'd1);
    rd(ad(10, 2), r); chk("R12 edge origin", r, 32'h0000_0020);
    wr(ad(9, 2), 32'h0);
    rd(ad(9, 2), r); chk("R9 zero write keeps", r, 32'h0000_0020);
    wr(ad(9, 2), 32'h0000_0020);
    rd(ad(9, 2), r); chk("R9 one write clears", r, '0);
    rd(ad(10, 2), r); chk("R12 cleared with pending", r, '0);
    chk("R10 irq low", W'(irq), '0);
    wr(ad(5, 2), '0);

    // R7 both edges on bank0 line 0
    wr(ad(5, 0), 32'h1); wr(ad(6, 0), 32'h1);
    set_pins(96'h1);
    rd(ad(9, 0), r); chk("R7 both edges rise", r, 32'h1);
    clear_all();
    set_pins(96'h0);
    rd(ad(9, 0), r); chk("R7 both edges fall", r, 32'h1);
    wr(ad(5, 0), '0); wr(ad(6, 0), '0);
    clear_all();

    // R8 high level reasserts through clear, R12 not edge
    wr(ad(7, 1), 32'h8);
    set_pins(96'h1 << 35);
    rd(ad(9, 1), r); chk("R8 high level", r, 32'h8);
    rd(ad(10, 1), r); chk("R12 level not edge", r, '0);
    wr(ad(9, 1), 32'h8);
    rd(ad(9, 1), r); chk("R8 level re-set after clear", r, 32'h8);
    set_pins('0);
    wr(ad(9, 1), 32'h8);
    rd(ad(9, 1), r); chk("R8 level gone clears", r, '0);
    wr(ad(7, 1), '0);

    // R8 low level
    wr(ad(8, 1), 32'h10);
    @(negedge clk);
    rd(ad(9, 1), r); chk("R8 low level", r, 32'h10);
    wr(ad(8, 1), '0);
    clear_all();

    // R11 polarity inverts detection
    wr(ad(1, 0), 32'h80);
    wr(ad(7, 0), 32'h80);
    repeat (2) @(negedge clk);
    rd(ad(9, 0), r); chk("R11 inverted low reads high", r, 32'h80);
    wr(ad(7, 0), '0);
    wr(ad(1, 0), '0);
    clear_all();
    rd(ad(9, 0), r); chk("R11 cleared", r, '0);

    // R10 irq across banks
    wr(ad(5, 0), 32'h2); wr(ad(5, 2), 32'h4);
    set_pins((96'h1 << 1) | (96'h1 << 66));
    chk("R10 irq two banks", W'(irq), 32'd1);
    wr(ad(9, 0), 32'h2);
    chk("R10 irq one bank left", W'(irq), 32'd1);
    wr(ad(9, 2), 32'h4);
    chk("R10 irq none left", W'(irq), '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule